// File: doc/BRIEF.md
# Multi-band NCO frequency bank

This block holds the tuning words for one receive channel of a digital down-converter. The channel has four phase-accumulating oscillators, one per band, and each oscillator owns a bank of four programmable 48-bit frequency entries. A packed selection byte picks the active entry of every oscillator. Its meaning depends on the band mode. In single-band mode the banks of the first two oscillators merge into one eight-entry set that feeds the first oscillator.

Frequency words are written byte by byte into shadow storage. They reach the running oscillators only when a two-write load sequence arrives on the update port. Each oscillator adds its active word to a 48-bit phase accumulator on every clock. A SYSREF pulse clears all accumulators when its mask routes it to the oscillators. Sine/cosine generation and mixing sit downstream and are not part of this block.

Top module: `nco_freq_bank`

## Requirements
- R1: While reset is asserted and right after it, every phase_out and word_out field is zero.
- R2: With band_mode 2'b10 or 2'b11 (quad), oscillator n (0..3) uses entry sel_byte[2n+1:2n] of its own bank.
- R3: With band_mode 2'b01 (dual), oscillator 0 uses entry sel_byte[1:0] of bank 0 and oscillator 1 uses entry sel_byte[3:2] of bank 1. Oscillators 2 and 3 get a zero word, so their accumulators hold. sel_byte[7:4] is ignored.
- R4: With band_mode 2'b00 (single), oscillator 0 uses entry sel_byte[1:0] of bank 0 when sel_byte[3] is 0 and of bank 1 when it is 1. sel_byte[2] and sel_byte[7:4] are ignored. Oscillators 1 to 3 get a zero word.
- R5: Entry e of bank b has index k = 4b+e. Byte j (0 = least significant) of its word is written at wr_addr = 6k+j. A written word does not change word_out until a load occurs.
- R6: A load happens when an update-port write of 0x30 directly follows an update-port write of 0x00, with no other update-port write in between. All 16 shadow words become active after that clock edge. A 0x30 not preceded in this way loads nothing.
- R7: On each clock, each phase accumulator adds its oscillator's word_out, modulo 2^48.
- R8: A change of sel_byte or band_mode shows on word_out in the same cycle. It enters the accumulator at the next edge and does not reset the accumulator.
- R9: sysref with sysref_to_nco high clears all four accumulators at the next edge. With sysref_to_nco low, sysref has no effect.
- R10: If a clearing SYSREF and a load fall on the same edge, the accumulators read zero after that edge. Accumulation then resumes with the newly loaded words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_mode | input | 2 | 00 single, 01 dual, 10/11 quad |
| sel_byte | input | 8 | Packed entry selection |
| wr_en | input | 1 | Frequency byte write strobe |
| wr_addr | input | 7 | Byte address into the shadow words |
| wr_data | input | 8 | Frequency byte |
| upd_en | input | 1 | Update-port write strobe |
| upd_data | input | 8 | Update-port value |
| sysref | input | 1 | SYSREF pulse |
| sysref_to_nco | input | 1 | Mask: route SYSREF to the accumulators |
| phase_out | output | 192 | Four 48-bit accumulators, oscillator 0 in the low bits |
| word_out | output | 192 | Four 48-bit active words, oscillator 0 in the low bits |

## Verification
The bench targets the corners of the selection mapping. These are the unused bit 2 and the bank-select bit 3 in single mode, and the ignored high nibble in dual mode. A wrong mapping there would feed an oscillator from the wrong bank, or leave an idle oscillator running. The bench rewrites the entry in use and issues broken update sequences (0x30 alone, or 0x00, 0x11, 0x30). A design that applies writes early would change the running frequency at once. A large word drives the accumulator through a 48-bit wrap. SYSREF is tried masked, unmasked and together with a load. A wrong priority there would leave a stale phase or a stale word.

// File: rtl/nco_freq_bank.sv
module nco_freq_bank #(
  parameter int WORD_W = 48,
  parameter int ADDR_W = $clog2(16 * ((WORD_W + 7) / 8))
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          band_mode,
  input  logic [7:0]          sel_byte,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                upd_en,
  input  logic [7:0]          upd_data,
  input  logic                sysref,
  input  logic                sysref_to_nco,
  output logic [4*WORD_W-1:0] phase_out,
  output logic [4*WORD_W-1:0] word_out
);
  localparam int NBYTE  = (WORD_W + 7) / 8;
  localparam int NWORDS = 16;

  logic [NBYTE*8-1:0] shadow [NWORDS];
  logic [WORD_W-1:0]  active [NWORDS];
  logic [WORD_W-1:0]  phase  [4];
  logic [3:0]         idx    [4];
  logic [3:0]         live;
  logic               armed;

  wire do_load = upd_en && (upd_data == 8'h30) && armed;
  wire clear   = sysref && sysref_to_nco;

  wire [ADDR_W-1:0] w_word = wr_addr / ADDR_W'(NBYTE);
  wire [ADDR_W-1:0] w_byte = wr_addr % ADDR_W'(NBYTE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else if (upd_en) armed <= (upd_data == 8'h00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) shadow[i] <= '0;
    end else if (wr_en && w_word < ADDR_W'(NWORDS)) begin
      shadow[w_word[3:0]][w_byte*8 +: 8] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) active[i] <= '0;
    end else if (do_load) begin
      for (int i = 0; i < NWORDS; i++) active[i] <= shadow[i][WORD_W-1:0];
    end

  always_comb begin
    for (int o = 0; o < 4; o++) idx[o] = 4'(o * 4) + {2'b00, sel_byte[2*o +: 2]};
    case (band_mode)
      2'b00: begin
        idx[0] = {1'b0, sel_byte[3], sel_byte[1:0]};
        live   = 4'b0001;
      end
      2'b01:   live = 4'b0011;
      default: live = 4'b1111;
    endcase
  end

  for (genvar o = 0; o < 4; o++) begin : g_osc
    assign word_out[o*WORD_W +: WORD_W] = live[o] ? active[idx[o]] : '0;
    assign phase_out[o*WORD_W +: WORD_W] = phase[o];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     phase[o] <= '0;
      else if (clear) phase[o] <= '0;
      else            phase[o] <= phase[o] + word_out[o*WORD_W +: WORD_W];
  end

  // R9
  sysref_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref && sysref_to_nco) |=> (phase_out == '0));

  // R3
  idle_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (band_mode == 2'b01 && !clear) |=> $stable(phase_out[4*WORD_W-1 -: WORD_W]));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load ##1 ($stable(sel_byte) && $stable(band_mode)) |-> $stable(word_out));

  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> phase_out[WORD_W-1:0] == $past(phase_out[WORD_W-1:0]) + $past(word_out[WORD_W-1:0]));
endmodule

// File: tb/nco_freq_bank_tb.sv
module nco_freq_bank_tb_top;
  localparam int W = 48;
  localparam logic [4:0] Z = 5'd31;
  // {mode, sel, expected index osc0..osc3}, index 31 means zero word
  localparam logic [29:0] VEC [10] = '{
    {2'b10, 8'hE4, 5'd0,  5'd5,  5'd10, 5'd15},  // R2
    {2'b10, 8'h1B, 5'd3,  5'd6,  5'd9,  5'd12},  // R2
    {2'b11, 8'h55, 5'd1,  5'd5,  5'd9,  5'd13},  // R2
    {2'b01, 8'h0E, 5'd2,  5'd7,  Z,     Z},      // R3
    {2'b01, 8'h01, 5'd1,  5'd4,  Z,     Z},      // R3
    {2'b01, 8'hF5, 5'd1,  5'd5,  Z,     Z},      // R3
    {2'b00, 8'h03, 5'd3,  Z,     Z,     Z},      // R4
    {2'b00, 8'h0A, 5'd6,  Z,     Z,     Z},      // R4
    {2'b00, 8'h0E, 5'd6,  Z,     Z,     Z},      // R4
    {2'b00, 8'hF9, 5'd5,  Z,     Z,     Z}       // R4
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] band_mode = 2'b10;
  logic [7:0] sel_byte = 0, wr_data = 0, upd_data = 0;
  logic [6:0] wr_addr = 0;
  logic wr_en = 0, upd_en = 0, sysref = 0, sysref_to_nco = 0;
  logic [4*W-1:0] phase_out, word_out;
  int errors = 0, checks = 0;

  always #5ns clk = ~clk;

  nco_freq_bank dut_i (.clk, .rst_n, .band_mode, .sel_byte, .wr_en, .wr_addr, .wr_data,
    .upd_en, .upd_data, .sysref, .sysref_to_nco, .phase_out, .word_out);

  function automatic logic [W-1:0] fw(int k);
    return 48'h1357_9BDF_0000 + 48'(k) * 48'h0000_1111_2223 + 48'(k);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(int k, logic [W-1:0] v);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk); wr_en = 1; wr_addr = 7'(k * 6 + j); wr_data = v[j*8 +: 8];
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic upd(logic [7:0] d);
    @(negedge clk); upd_en = 1; upd_data = d;
  endtask

  task automatic upd_idle();
    @(negedge clk); upd_en = 0;
  endtask

  function automatic logic [W-1:0] osc(logic [4*W-1:0] v, int o);
    return v[o*W +: W];
  endfunction

  initial begin
    #2ms;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] wbig, vnew, p0, p1;
    wbig = 48'hC000_0000_0001;
    vnew = 48'h00AB_CDEF_1234;
    repeat (3) @(negedge clk);
    for (int o = 0; o < 4; o++) begin
      chk("R1 reset phase", osc(phase_out, o), '0);
      chk("R1 reset word", osc(word_out, o), '0);
    end
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset phase", osc(phase_out, 0), '0);

    for (int k = 0; k < 16; k++) put_word(k, fw(k));
    chk("R5 no load yet", osc(word_out, 0), '0);
    upd(8'h00); upd(8'h30); upd_idle();

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      band_mode = VEC[i][29:28]; sel_byte = VEC[i][27:20];
      #1;
      for (int o = 0; o < 4; o++) begin
        logic [4:0] e;
        e = VEC[i][19 - 5*o -: 5];
        chk($sformatf("R2/R3/R4 vec%0d osc%0d", i, o), osc(word_out, o),
            (e == Z) ? '0 : fw(int'(e)));
      end
    end

    // R7 wrap
    band_mode = 2'b10; sel_byte = 8'h00;
    put_word(0, wbig); upd(8'h00); upd(8'h30); upd_idle();
    @(negedge clk); sysref = 1; sysref_to_nco = 1;
    @(negedge clk); sysref = 0;
    for (int o = 0; o < 4; o++) chk("R9 clear", osc(phase_out, o), '0);
    repeat (3) @(negedge clk);
    chk("R7 wrap osc0", osc(phase_out, 0), 48'(3) * wbig);
    chk("R7 osc1", osc(phase_out, 1), 48'(3) * fw(4));

    // R8
    sel_byte = 8'h01; #1;
    chk("R8 word now", osc(word_out, 0), fw(1));
    @(negedge clk);
    chk("R8 no reset", osc(phase_out, 0), 48'(3) * wbig + fw(1));
    chk("R8 osc1", osc(phase_out, 1), 48'(4) * fw(4));

    // R9 masked
    p0 = osc(phase_out, 0);
    sysref = 1; sysref_to_nco = 0;
    @(negedge clk); sysref = 0;
    chk("R9 masked", osc(phase_out, 0), p0 + fw(1));

    // R5, R6
    sel_byte = 8'h00;
    put_word(0, vnew);
    chk("R5 hold", osc(word_out, 0), wbig);
    upd(8'h30); upd_idle();
    chk("R6 lone 0x30", osc(word_out, 0), wbig);
    upd(8'h00); upd(8'h11); upd(8'h30); upd_idle();
    chk("R6 broken sequence", osc(word_out, 0), wbig);

    // R10
    upd(8'h00);
    @(negedge clk); upd_data = 8'h30; sysref = 1; sysref_to_nco = 1;
    @(negedge clk); upd_en = 0; sysref = 0;
    chk("R10 cleared", osc(phase_out, 0), '0);
    chk("R10 new word", osc(word_out, 0), vnew);
    p1 = osc(phase_out, 1);
    chk("R10 osc1 cleared", p1, '0);
    @(negedge clk);
    chk("R10 resume", osc(phase_out, 0), vnew);

    // R3 idle oscillators hold
    band_mode = 2'b01;
    p0 = osc(phase_out, 3);
    repeat (2) @(negedge clk);
    chk("R3 idle osc3", osc(phase_out, 3), p0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule